// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous request port and one 16-bit asynchronous static RAM. A client presents an address, write data, a direction bit and a two-bit lane mask under a valid/ready handshake. The sequencer turns each accepted request into a complete memory cycle on the RAM's control pins: a positive and a negative chip enable, a write strobe, an output enable and two active-low lane selects. The data bus is carried as an output value, an output-enable and an input value so that the pad ring can build the tri-state driver.

Every interval the memory needs is a parameter counted in clock cycles. These are the read access window, the read cycle length, the write strobe width, the data setup before the strobe rises, the write cycle length and the bus turnaround after a read. A read drives the strobes for its whole window and captures the bus on the last cycle. It returns the data with a single-cycle valid pulse, with unselected lanes forced to zero. A write drives the bus only while the write strobe is low. The address moves only while every strobe is idle, so no access ever sees the address change under it.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, the negative chip enable, write strobe, output enable and both lane selects are high, the positive chip enable is low, the bus output-enable is low and `req_ready` is high.
- R2: A read holds both chip enables active and the output enable low for exactly max(T_RD_ACC, T_RD_CYC) cycles, and the write strobe stays high for the whole read.
- R3: A read returns the bus value sampled in the last cycle of its window. `rsp_valid` is high for exactly one cycle, the first cycle after the strobes drop. Lanes whose mask bit is 0 read as zero.
- R4: A write holds the write strobe low for exactly max(T_WR_PULSE, T_WR_SETUP) cycles with the output enable high. The bus is driven with the request data in every one of those cycles.
- R5: The bus output-enable is high only while the write strobe is low, never while the RAM output enable is low, and drops on the same edge the write strobe rises.
- R6: Mask bit 0 enables bits 7:0 and drives `sram_lb_n` low during the access. Mask bit 1 enables bits 15:8 and drives `sram_ub_n` low. A value of 1 selects the lane. A write with mask 00 leaves memory unchanged.
- R7: `sram_addr` changes only on an edge before which the write strobe was high and the chip enables were inactive. It holds steady for the whole access.
- R8: After a read, the bus is not driven until at least T_TURN cycles after the output enable rises.
- R9: `req_ready` falls on the edge that accepts a request. A read keeps it low for max(T_RD_ACC, T_RD_CYC) cycles. A write keeps it low for the turnaround wait, plus the strobe width, plus whatever remains of T_WR_CYC after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce1_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_lb_n | output | 1 | Active-low low-lane select |
| sram_ub_n | output | 1 | Active-low high-lane select |
| sram_dq_out | output | 16 | Value to drive on the data bus |
| sram_dq_oe | output | 1 | Bus driver enable |
| sram_dq_in | input | 16 | Value seen on the data bus |

## Verification
The bench issues writes immediately after reads, and also after one to three idle cycles. This exercises the turnaround counter at both ends. An off-by-one there shows up as a write driving the bus while the RAM outputs are still switching off, or as a ready-low window one cycle off. The memory model drives junk on deselected lanes. A design that forgets to mask them returns that junk in the response. Partial-lane writes and a mask-00 write are read back, so a wrong lane-select polarity corrupts the neighbouring byte. Strobe window lengths are counted per access, which exposes a read sampled before its access time or a write strobe too short for the setup rule.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WGAP,
    ST_WPULSE,
    ST_WREC
  } seq_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycles the read strobes stay on: covers access time and cycle time
  function automatic int unsigned rd_hold(input int unsigned acc, input int unsigned cyc);
    return max_u(max_u(acc, cyc), 1);
  endfunction

  // cycles the write strobe stays low: data is driven for all of them
  function automatic int unsigned wr_hold(input int unsigned pulse, input int unsigned setup);
    return max_u(max_u(pulse, setup), 1);
  endfunction

  // idle cycles needed after the strobe to reach the write cycle time
  function automatic int unsigned wr_tail(input int unsigned cyc, input int unsigned hold);
    return (cyc > hold) ? (cyc - hold) : 0;
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned n);
    int unsigned r;
    r = 1;
    while ((64'd1 << r) <= 64'(n)) r++;
    return r;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int unsigned RD_LEN  = 5,
  parameter int unsigned WR_LEN  = 4,
  parameter int unsigned WR_TAIL = 1,
  parameter int unsigned TURN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic phase_rd,
  output logic phase_wr,
  output logic rd_last
);

  localparam int unsigned CW = cnt_bits(max_u(max_u(RD_LEN, WR_LEN), WR_TAIL));
  localparam int unsigned TW = cnt_bits(TURN);
  localparam logic [CW-1:0] RD_LOAD   = CW'(RD_LEN - 1);
  localparam logic [CW-1:0] WR_LOAD   = CW'(WR_LEN - 1);
  localparam logic [CW-1:0] TAIL_LOAD = CW'((WR_TAIL > 0) ? WR_TAIL - 1 : 0);
  localparam logic [TW-1:0] TURN_LOAD = TW'(TURN);

  seq_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] turn_q;
  logic          cnt_zero;
  logic          turn_ok;

  assign cnt_zero  = (cnt_q == '0);
  assign turn_ok   = (turn_q <= TW'(1));
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign phase_rd  = (state_q == ST_RD);
  assign phase_wr  = (state_q == ST_WPULSE);
  assign rd_last   = phase_rd && cnt_zero;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (!req_write) begin
            state_d = ST_RD;
            cnt_d   = RD_LOAD;
          end else if (turn_ok) begin
            state_d = ST_WPULSE;
            cnt_d   = WR_LOAD;
          end else begin
            state_d = ST_WGAP;
          end
        end
      end
      ST_RD: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_WGAP: begin
        if (turn_ok) begin
          state_d = ST_WPULSE;
          cnt_d   = WR_LOAD;
        end
      end
      ST_WPULSE: begin
        if (cnt_zero) begin
          if (WR_TAIL != 0) begin
            state_d = ST_WREC;
            cnt_d   = TAIL_LOAD;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WREC: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      turn_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (rd_last)            turn_q <= TURN_LOAD;
      else if (turn_q != '0)  turn_q <= turn_q - 1'b1;
    end
  end

  // run-length counters seen only by the assertions below
  logic [CW:0] rd_run_q, wr_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_run_q <= '0;
      wr_run_q <= '0;
    end else begin
      rd_run_q <= phase_rd ? rd_run_q + 1'b1 : '0;
      wr_run_q <= phase_wr ? wr_run_q + 1'b1 : '0;
    end
  end

  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  p_rd_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_rd) |-> (rd_run_q == (CW+1)'(RD_LEN)));
  p_wr_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_wr) |-> (wr_run_q == (CW+1)'(WR_LEN)));
  p_phase_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase_rd && phase_wr));

endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned TURN   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic              phase_rd,
  input  logic              phase_wr,
  input  logic              rd_last,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce1_n,
  output logic              sram_ce2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int unsigned TW = cnt_bits(TURN);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] lane_keep;
  logic              ce_on;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_keep[g*8 +: 8] = {8{mask_q[g]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  assign ce_on       = phase_rd || phase_wr;
  assign sram_addr   = addr_q;
  assign sram_ce1_n  = !ce_on;
  assign sram_ce2    = ce_on;
  assign sram_we_n   = !phase_wr;
  assign sram_oe_n   = !phase_rd;
  assign sram_lb_n   = !(ce_on && mask_q[0]);
  assign sram_ub_n   = !(ce_on && mask_q[1]);
  assign sram_dq_oe  = phase_wr;
  assign sram_dq_out = phase_wr ? wdata_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_last;
      if (rd_last) rsp_rdata <= sram_dq_in & lane_keep;
    end
  end

  // cycles since the RAM output enable last went high, saturating at TURN
  logic [TW-1:0] oe_off_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                      oe_off_q <= TW'(TURN);
    else if (!sram_oe_n)             oe_off_q <= '0;
    else if (oe_off_q < TW'(TURN))   oe_off_q <= oe_off_q + 1'b1;
  end

  p_addr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sram_addr) |-> ($past(sram_we_n) && $past(sram_ce1_n) && !$past(sram_ce2)));
  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (sram_oe_n && !sram_we_n));
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> !sram_dq_oe);
  p_read_we_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> sram_we_n);
  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (oe_off_q >= TW'(TURN)));
  p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_lane_in_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_lb_n || !sram_ub_n) |-> (!sram_ce1_n && sram_ce2));

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned T_RD_ACC   = 4,
  parameter int unsigned T_RD_CYC   = 5,
  parameter int unsigned T_WR_PULSE = 4,
  parameter int unsigned T_WR_SETUP = 3,
  parameter int unsigned T_WR_CYC   = 5,
  parameter int unsigned T_TURN     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce1_n,
  output logic              sram_ce2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n,
  output logic [15:0]       sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [15:0]       sram_dq_in
);

  localparam int unsigned RD_LEN  = rd_hold(T_RD_ACC, T_RD_CYC);
  localparam int unsigned WR_LEN  = wr_hold(T_WR_PULSE, T_WR_SETUP);
  localparam int unsigned WR_TAIL = wr_tail(T_WR_CYC, WR_LEN);

  logic accept, phase_rd, phase_wr, rd_last;

  sram_seq_fsm #(
    .RD_LEN (RD_LEN),
    .WR_LEN (WR_LEN),
    .WR_TAIL(WR_TAIL),
    .TURN   (T_TURN)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_ready(req_ready),
    .accept   (accept),
    .phase_rd (phase_rd),
    .phase_wr (phase_wr),
    .rd_last  (rd_last)
  );

  sram_seq_pins #(
    .ADDR_W(ADDR_W),
    .TURN  (T_TURN)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mask   (req_mask),
    .phase_rd   (phase_rd),
    .phase_wr   (phase_wr),
    .rd_last    (rd_last),
    .sram_addr  (sram_addr),
    .sram_ce1_n (sram_ce1_n),
    .sram_ce2   (sram_ce2),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_lb_n  (sram_lb_n),
    .sram_ub_n  (sram_ub_n),
    .sram_dq_out(sram_dq_out),
    .sram_dq_oe (sram_dq_oe),
    .sram_dq_in (sram_dq_in),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: tb/tb_sram_seq_ctrl.sv
module tb_sram_seq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int RACC  = 4;
  localparam int RCYC  = 5;
  localparam int WPUL  = 4;
  localparam int WSU   = 3;
  localparam int WCYC  = 5;
  localparam int TURN  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe;
  logic [15:0] sram_dq_out, sram_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_seq_ctrl #(
    .ADDR_W(AW), .T_RD_ACC(RACC), .T_RD_CYC(RCYC), .T_WR_PULSE(WPUL),
    .T_WR_SETUP(WSU), .T_WR_CYC(WCYC), .T_TURN(TURN)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n),
    .sram_ub_n(sram_ub_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  // memory model: deselected lanes float, modelled as junk
  logic [15:0] mem [64];
  logic [15:0] shadow [64];
  wire sel = !sram_ce1_n && sram_ce2;
  assign sram_dq_in = (sel && !sram_oe_n && sram_we_n) ?
    {sram_ub_n ? 8'hA5 : mem[sram_addr][15:8], sram_lb_n ? 8'h5A : mem[sram_addr][7:0]} : 16'hC3C3;

  always @(posedge clk) begin
    if (sel && !sram_we_n) begin
      if (!sram_lb_n) mem[sram_addr][7:0]  <= sram_dq_out[7:0];
      if (!sram_ub_n) mem[sram_addr][15:8] <= sram_dq_out[15:8];
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit seen_rd = 1'b0;
  int rd_end = 0;

  function automatic int exp_rd_len();
    if (RACC >= RCYC) return RACC;
    return RCYC;
  endfunction
  function automatic int exp_wr_len();
    if (WPUL >= WSU) return WPUL;
    return WSU;
  endfunction
  function automatic int exp_tail();
    int t;
    t = WCYC - exp_wr_len();
    return (t < 0) ? 0 : t;
  endfunction
  function automatic logic [15:0] pick(input logic [15:0] w, input logic [1:0] m);
    pick = 16'h0;
    if (m[0]) pick[7:0]  = w[7:0];
    if (m[1]) pick[15:8] = w[15:8];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic op(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                    input logic [1:0] m, input int idle);
    int busy, oe_lo, we_lo, acc, first_drive, gap;
    bit lane_ok, addr_ok, data_ok, rsp_quiet, we_in_rd;
    repeat (idle) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    acc = cyc;
    busy = 0; oe_lo = 0; we_lo = 0; first_drive = -1;
    lane_ok = 1; addr_ok = 1; data_ok = 1; rsp_quiet = 1; we_in_rd = 1;
    for (int g = 0; g < 1000; g++) begin
      if (req_ready) break;
      busy++;
      if (rsp_valid) rsp_quiet = 0;
      if (!sram_oe_n) begin
        oe_lo++;
        if (!sram_we_n) we_in_rd = 0;
      end
      if (!sram_we_n) we_lo++;
      if (sel) begin
        if (sram_lb_n != !m[0] || sram_ub_n != !m[1]) lane_ok = 0;
        if (sram_addr != a) addr_ok = 0;
      end
      if (sram_dq_oe) begin
        if (first_drive < 0) first_drive = cyc;
        if (sram_dq_out != d || !sram_oe_n || sram_we_n) data_ok = 0;
      end
      if (!sram_we_n && !sram_dq_oe) data_ok = 0;
      @(negedge clk);
    end
    chk(lane_ok, "R6 lane selects follow mask", {sram_ub_n, sram_lb_n}, ~m);
    chk(addr_ok, "R7 address steady in access", sram_addr, a);
    chk(rsp_quiet, "R3 no response while busy", 1, 0);
    chk(!sram_dq_oe && sram_we_n && sram_oe_n && sram_ce1_n && !sram_ce2,
        "R5 strobes idle when ready", {sram_dq_oe, sram_we_n, sram_oe_n}, 3'b011);
    if (!wr) begin
      chk(busy == exp_rd_len(), "R9 read ready-low length", busy, exp_rd_len());
      chk(oe_lo == exp_rd_len(), "R2 read window", oe_lo, exp_rd_len());
      chk(we_lo == 0 && we_in_rd, "R2 write strobe high in read", we_lo, 0);
      chk(rsp_valid, "R3 response pulse", rsp_valid, 1);
      chk(rsp_rdata == pick(shadow[a], m), "R3 read data", rsp_rdata, pick(shadow[a], m));
      seen_rd = 1'b1;
      rd_end = cyc;
    end else begin
      gap = 0;
      if (seen_rd && (acc - rd_end) < TURN) gap = TURN - (acc - rd_end);
      chk(busy == gap + exp_wr_len() + exp_tail(), "R9 write ready-low length",
          busy, gap + exp_wr_len() + exp_tail());
      chk(we_lo == exp_wr_len(), "R4 write strobe width", we_lo, exp_wr_len());
      chk(oe_lo == 0 && data_ok, "R4 data driven with output enable high", oe_lo, 0);
      if (seen_rd)
        chk(first_drive - rd_end >= TURN, "R8 turnaround before drive",
            first_drive - rd_end, TURN);
      if (m[0]) shadow[a][7:0]  = d[7:0];
      if (m[1]) shadow[a][15:8] = d[15:8];
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'(i * 16'h0301 + 16'h1F0E);
      shadow[i] = 16'(i * 16'h0301 + 16'h1F0E);
    end
  end

  initial begin
    void'($urandom(32'd20240613));
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && sram_lb_n && sram_ub_n && !sram_dq_oe,
        "R1 strobes in reset", {sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe}, 5'b10110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && sram_ce1_n && sram_we_n && sram_oe_n && !sram_dq_oe && !rsp_valid,
        "R1 state after reset", {req_ready, sram_dq_oe}, 2'b10);

    // directed corners
    op(1'b0, 6'd3, 16'h0, 2'b11, 0);          // word read
    op(1'b1, 6'd3, 16'hBEEF, 2'b11, 0);       // write right after read: turnaround
    op(1'b0, 6'd3, 16'h0, 2'b11, 0);
    op(1'b1, 6'd3, 16'h1234, 2'b01, 3);       // low lane only, after long idle
    op(1'b0, 6'd3, 16'h0, 2'b11, 0);          // R6 upper byte kept
    op(1'b1, 6'd3, 16'h5678, 2'b10, 0);       // high lane only
    op(1'b1, 6'd3, 16'hFFFF, 2'b00, 0);       // R6 mask 00 write has no effect
    op(1'b0, 6'd3, 16'h0, 2'b11, 1);
    op(1'b0, 6'd3, 16'h0, 2'b00, 0);          // R3 no lanes: response zero
    op(1'b0, 6'd9, 16'h0, 2'b01, 0);          // R3 high lane junk masked
    op(1'b0, 6'd9, 16'h0, 2'b10, 0);
    op(1'b1, 6'd63, 16'hA0A0, 2'b11, 2);
    op(1'b1, 6'd0, 16'h0B0B, 2'b11, 0);       // write after write
    op(1'b0, 6'd63, 16'h0, 2'b11, 0);
    op(1'b0, 6'd0, 16'h0, 2'b11, 0);

    for (int n = 0; n < 400; n++) begin
      op(1'($urandom), AW'($urandom), 16'($urandom), 2'($urandom), int'($urandom % 4));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog expired actual=%0d expected=<150000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule